// File: doc/BRIEF.md
# Shared-Counter Ramp Conversion Bank

This block is the digital half of a single-slope conversion carried out on many sampling cells at once. A start request opens a conversion window: the block raises a ramp-enable output that drives an external ramp generator, and a single shared binary counter advances once per clock while the ramp climbs. Every cell owns one comparator that watches the common ramp. Each cell has a result register that freezes the counter value in the first cycle its comparator reports high. Later activity on that comparator during the same window has no effect.

After a fixed window of 2^CNT_W counts the ramp enable drops and a one-cycle done pulse marks the end of the window. A cell that never tripped is given the saturated code. The stored words then leave the block one per transfer on a valid/ready stream, lowest cell first. The producer side obeys the usual rules: once valid is raised it stays high, and data and last stay fixed, until the consumer takes the word with ready. The consumer may hold ready low for as long as it likes. No new conversion can begin until the last word has been taken.

Top module: `wlk_adc_bank`

## Requirements
- R1: After reset, ramp_en_o, res_valid_o, res_last_o and done_o are all low.
- R2: A start_i sampled high while the block is idle raises ramp_en_o in the next cycle, and ramp_en_o then stays high for exactly 2^CNT_W (4096) consecutive cycles. During the k-th of those cycles, counted from 0, the shared count equals k.
- R3: A cell whose comparator is first sampled high in ramp cycle k stores the value k. This includes k = 0 and k = 4095.
- R4: Once a cell has stored a value, further comparator toggles in the same window leave that value unchanged.
- R5: A cell whose comparator is never high during the window stores the saturated value 4095.
- R6: done_o is high for exactly one cycle. That cycle is the first cycle in which ramp_en_o is low again.
- R7: Streaming begins in the same cycle as done_o. The block delivers exactly N_CELLS words in ascending cell order, cell 0 first, and res_valid_o falls after the last word is accepted.
- R8: While res_valid_o is high and res_ready_i is low, the next cycle still has res_valid_o high with res_data_o and res_last_o unchanged.
- R9: start_i is ignored while a ramp window is running and while words remain to be streamed. In particular, ramp_en_o never rises while res_valid_o is high.
- R10: res_last_o is high only together with res_valid_o, and only on the word of cell N_CELLS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a conversion window (taken only when idle) |
| cmp_i | input | N_CELLS | Per-cell comparator outputs, bit i belongs to cell i |
| res_ready_i | input | 1 | Stream consumer ready |
| ramp_en_o | output | 1 | High for the duration of the ramp window |
| res_valid_o | output | 1 | Stream word valid |
| res_data_o | output | CNT_W | Stored count of the current cell |
| res_last_o | output | 1 | Marks the word of the highest cell |
| done_o | output | 1 | One-cycle end-of-window pulse |

## Verification
On every cycle, the bound checker enforces the length of the ramp window, the shape and placement of the done pulse, stream stability under back-pressure, the rule that a ramp never overlaps a stream, and where the last flag may appear. The values actually stored per cell cannot be seen by those properties. Only the bench scenarios show them: first-trip capture at both ends of the count, immunity to later toggles, saturation of silent cells, and ascending delivery order. The bench scoreboard predicts these from comparator schedules it drives itself, and it runs under both steady and randomly stalled ready.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_READ = 2'd2
  } wlk_state_e;
endpackage

// File: rtl/wlk_ramp_counter.sv
module wlk_ramp_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (run_i) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;
  assign last_o  = (count_q == TOP);
endmodule

// File: rtl/wlk_latch_bank.sv
module wlk_latch_bank #(
  parameter int N_CELLS = 8,
  parameter int CNT_W   = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm_i,
  input  logic                          run_i,
  input  logic                          finish_i,
  input  logic [N_CELLS-1:0]            cmp_i,
  input  logic [CNT_W-1:0]              count_i,
  output logic [N_CELLS-1:0][CNT_W-1:0] words_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    logic             held_q;
    logic [CNT_W-1:0] word_q;

    // capture on the first high comparator sample, or saturate at the window end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q <= 1'b0;
        word_q <= '0;
      end else if (arm_i) begin
        held_q <= 1'b0;
      end else if (run_i && !held_q && (cmp_i[g] || finish_i)) begin
        held_q <= 1'b1;
        word_q <= cmp_i[g] ? count_i : SAT;
      end
    end

    assign words_o[g] = word_q;
  end
endmodule

// File: rtl/wlk_stream_out.sv
module wlk_stream_out #(
  parameter int N_CELLS = 8,
  parameter int CNT_W   = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [N_CELLS-1:0][CNT_W-1:0] words_i,
  input  logic                          ready_i,
  output logic                          valid_o,
  output logic [CNT_W-1:0]              data_o,
  output logic                          last_o,
  output logic                          finished_o
);
  localparam int IW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_CELLS - 1);

  logic          active_q;
  logic [IW-1:0] idx_q;
  logic          take;

  assign take = active_q && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (take) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign valid_o    = active_q;
  assign data_o     = words_i[idx_q];
  assign last_o     = active_q && (idx_q == LAST_IDX);
  assign finished_o = take && (idx_q == LAST_IDX);
endmodule

// File: rtl/wlk_adc_bank.sv
module wlk_adc_bank #(
  parameter int N_CELLS = 8,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [N_CELLS-1:0] cmp_i,
  input  logic               res_ready_i,
  output logic               ramp_en_o,
  output logic               res_valid_o,
  output logic [CNT_W-1:0]   res_data_o,
  output logic               res_last_o,
  output logic               done_o
);
  import wlk_pkg::*;

  wlk_state_e                  state_q;
  logic                        arm;
  logic                        run;
  logic                        cnt_last;
  logic                        finish;
  logic                        stream_fin;
  logic                        done_q;
  logic [CNT_W-1:0]            count;
  logic [N_CELLS-1:0][CNT_W-1:0] words;

  assign arm    = (state_q == ST_IDLE) && start_i;
  assign run    = (state_q == ST_RUN);
  assign finish = run && cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      case (state_q)
        ST_IDLE: if (start_i)    state_q <= ST_RUN;
        ST_RUN:  if (cnt_last)   state_q <= ST_READ;
        ST_READ: if (stream_fin) state_q <= ST_IDLE;
        default:                 state_q <= ST_IDLE;
      endcase
    end
  end

  wlk_ramp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (arm),
    .run_i   (run),
    .count_o (count),
    .last_o  (cnt_last)
  );

  wlk_latch_bank #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .run_i    (run),
    .finish_i (finish),
    .cmp_i    (cmp_i),
    .count_i  (count),
    .words_o  (words)
  );

  wlk_stream_out #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (finish),
    .words_i    (words),
    .ready_i    (res_ready_i),
    .valid_o    (res_valid_o),
    .data_o     (res_data_o),
    .last_o     (res_last_o),
    .finished_o (stream_fin)
  );

  assign ramp_en_o = run;
  assign done_o    = done_q;
endmodule

// File: rtl/wlk_adc_bank_chk.sv
module wlk_adc_bank_chk #(
  parameter int N_CELLS = 8,
  parameter int CNT_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [N_CELLS-1:0] cmp_i,
  input logic               res_ready_i,
  input logic               ramp_en_o,
  input logic               res_valid_o,
  input logic [CNT_W-1:0]   res_data_o,
  input logic               res_last_o,
  input logic               done_o
);
  localparam logic [CNT_W:0] WINDOW = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] high_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         high_run_q <= '0;
    else if (ramp_en_o) high_run_q <= high_run_q + 1'b1;
    else                high_run_q <= '0;
  end

  assert_ramp_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en_o |-> (high_run_q < WINDOW));

  assert_ramp_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_en_o) |-> (high_run_q == WINDOW));

  assert_done_at_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_en_o) |-> done_o);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_starts_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (res_valid_o && !ramp_en_o));

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o) && $stable(res_last_o)));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid_o && ramp_en_o));

  assert_last_in_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_last_o |-> res_valid_o);

  assert_stream_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_last_o && res_ready_i) |=> !res_valid_o);
endmodule

bind wlk_adc_bank wlk_adc_bank_chk #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmp_i       (cmp_i),
  .res_ready_i (res_ready_i),
  .ramp_en_o   (ramp_en_o),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o),
  .res_last_o  (res_last_o),
  .done_o      (done_o)
);

// File: tb/wlk_adc_bank_bench.sv
module wlk_adc_bank_bench;
  localparam int N_CELLS = 8;
  localparam int CNT_W   = 12;
  localparam int FULL    = 1 << CNT_W;
  localparam int SAT     = FULL - 1;
  localparam int NEVER   = FULL + 100;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [N_CELLS-1:0] cmp_i = '0;
  logic               res_ready_i = 1'b1;
  logic               ramp_en_o;
  logic               res_valid_o;
  logic [CNT_W-1:0]   res_data_o;
  logic               res_last_o;
  logic               done_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int thr_a[N_CELLS];
  bit toggle_mode = 1'b0;
  bit stall_mode  = 1'b0;
  bit finished    = 1'b0;
  int mon_idx     = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  wlk_adc_bank #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_wlk_adc_bank (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .res_ready_i(res_ready_i), .ramp_en_o(ramp_en_o), .res_valid_o(res_valid_o),
    .res_data_o(res_data_o), .res_last_o(res_last_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // ready driver
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    res_ready_i <= stall_mode ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  initial begin
    logic prev_stall;
    logic [CNT_W-1:0] prev_data;
    prev_stall = 1'b0;
    prev_data  = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          // R8: a stalled word stays offered unchanged
          chk(res_valid_o === 1'b1 && res_data_o === prev_data, "R8",
              int'(res_data_o), int'(prev_data));
        end
        if (res_valid_o && res_ready_i) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected word", int'(res_data_o), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            // R3 R4 R5 R7: value and order per cell
            chk(int'(res_data_o) == e, $sformatf("R7 cell %0d", mon_idx), int'(res_data_o), e);
            // R10: last flag only on the highest cell
            chk(res_last_o == (mon_idx == N_CELLS - 1), "R10", int'(res_last_o),
                int'(mon_idx == N_CELLS - 1));
            mon_idx = (mon_idx == N_CELLS - 1) ? 0 : mon_idx + 1;
          end
        end
        prev_stall = res_valid_o && !res_ready_i;
        prev_data  = res_data_o;
      end
    end
  end

  task automatic convert(input bit poke_start);
    for (int i = 0; i < N_CELLS; i++) exp_q.push_back(thr_a[i] < FULL ? thr_a[i] : SAT);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < FULL; k++) begin
      for (int i = 0; i < N_CELLS; i++) begin
        if (k < thr_a[i]) cmp_i[i] = 1'b0;
        else if (toggle_mode) cmp_i[i] = ((k - thr_a[i]) % 3) != 1;
        else cmp_i[i] = 1'b1;
      end
      if (k == 0)        chk(ramp_en_o === 1'b1, "R2 ramp up", int'(ramp_en_o), 1);
      if (k == FULL - 1) chk(ramp_en_o === 1'b1, "R2 ramp held", int'(ramp_en_o), 1);
      if (poke_start) start_i = (k == FULL / 2);
      if (k == FULL - 1) @(negedge clk);
      else @(negedge clk);
    end
    // first cycle after the window
    cmp_i   = '0;
    start_i = 1'b0;
    chk(ramp_en_o === 1'b0, "R2 ramp down", int'(ramp_en_o), 0);
    chk(done_o === 1'b1, "R6 done", int'(done_o), 1);
    chk(res_valid_o === 1'b1, "R7 stream starts", int'(res_valid_o), 1);
    @(negedge clk);
    chk(done_o === 1'b0, "R6 done single", int'(done_o), 0);
    if (poke_start && res_valid_o) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      #2;
      chk(ramp_en_o === 1'b0, "R9 start during stream", int'(ramp_en_o), 0);
    end
    while (res_valid_o) @(negedge clk);
    #2;
    chk(exp_q.size() == 0, "R7 word count", exp_q.size(), 0);
    chk(ramp_en_o === 1'b0, "R9 no restart", int'(ramp_en_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ramp_en_o === 1'b0, "R1 ramp", int'(ramp_en_o), 0);
    chk(res_valid_o === 1'b0, "R1 valid", int'(res_valid_o), 0);
    chk(done_o === 1'b0, "R1 done", int'(done_o), 0);
    chk(res_last_o === 1'b0, "R1 last", int'(res_last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // plain schedule, ends of the count, a silent cell, steady ready
    thr_a = '{0, 5, 100, SAT, NEVER, 2000, 1, 3000};
    convert(1'b0);

    // toggling comparators, stalled ready, start pokes mid-window and mid-stream
    toggle_mode = 1'b1;
    stall_mode  = 1'b1;
    thr_a = '{4000, 7, 0, 1234, 64, NEVER, SAT, 2};
    convert(1'b1);

    // no cell trips: all saturate (R5)
    toggle_mode = 1'b0;
    thr_a = '{NEVER, NEVER, NEVER, NEVER, NEVER, NEVER, NEVER, NEVER};
    convert(1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule